// File: doc/BRIEF.md
# Ganged-Period PWM Controller

This block produces several pulse-width-modulated outputs that share one time base. One prescaler divides the input clock into local ticks, and one 8-bit counter steps through a fixed period of 256 local ticks. Every channel compares that shared count against its own duty value. A single enable bit starts or stops all channels at once. Because the channels share the counter, every output rises at the same instant and only the falling edges differ from channel to channel.

Software drives the block over a simple register bus. Writes take one clock, and reads are combinational from the address. Duty and prescale writes go into staged registers. The working copies are refreshed only when the period wraps, so a change never cuts a pulse short. An optional interrupt marks each period boundary.

Top module: `gpwm_top`

## Requirements
- R1: The duty register of channel c sits at byte address 4*c and holds 8 bits (write data bits [7:0]). Reads return the staged value, and the upper bits read as zero.
- R2: The control register sits at address 0x50. Bits [3:0] hold the low nibble and bits [14:11] the high nibble of an 8-bit prescale value, and bit 9 is the shared enable. All other bits of this register read as zero and ignore writes. Any unmapped address also reads as zero.
- R3: The interrupt-enable register sits at address 0x54 and stores its flag in bit 0. All other bits read as zero.
- R4: One local tick occurs every prescale+1 clocks, and a period always lasts 256 local ticks.
- R5: While enabled, all outputs are high at count 0. Channel c stays high while the count is at or below its duty value N, so it is high for N+1 ticks per period.
- R6: A duty value of 0 gives a pulse one local tick wide.
- R7: A duty value of 255 holds the output high for the whole period.
- R8: Writes to duty or prescale take effect only at the wrap from count 255 to count 0. While the block is disabled, the working copies follow the staged values.
- R9: The interrupt output pulses high for exactly one clock, in the clock after each wrap. It pulses only while both the enable and the interrupt-enable flag are set.
- R10: While the enable is clear, all outputs are low, and the counter and divider are held at zero. Setting the enable starts a fresh period at count 0 on the next clock, with all outputs high.
- R11: Reset clears every register and drives all outputs and the interrupt low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one clock per write |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pwm_o | output | NCH (4) | One PWM output per channel |
| irq_o | output | 1 | One-clock pulse at each period wrap |

## Verification
A behavioural model runs beside the block and is compared against it on every clock. The channels are loaded with a mix of duty values, 0, 7, 100 and 255, so that the single-tick pulse, the continuous high and ordinary widths can be told apart in the same period. The prescale is switched from 0 to 19, a value whose bits fall in both nibble fields; a correct pulse width then shows that the two nibble fields are assembled in the right order. A duty write made in the middle of a period checks that the old width holds until the wrap. Further runs with the enable cleared and with the interrupt flag cleared show that the outputs and the interrupt are held off.

// File: rtl/gpwm_pkg.sv
package gpwm_pkg;
  localparam int unsigned PS_W      = 8;
  localparam int unsigned CTRL_OFS  = 'h50;
  localparam int unsigned IEN_OFS   = 'h54;
  localparam int unsigned PS_LO_LSB = 0;
  localparam int unsigned PS_HI_LSB = 11;
  localparam int unsigned EN_POS    = 9;
  localparam int unsigned IEN_POS   = 0;
  localparam int unsigned NIB       = PS_W / 2;
endpackage

// File: rtl/gpwm_regs.sv
module gpwm_regs
  import gpwm_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic [NCH-1:0][CW-1:0]  duty_stg_o,
  output logic [PS_W-1:0]         ps_stg_o,
  output logic                    en_o,
  output logic                    ien_o
);
  logic [NCH-1:0][CW-1:0] duty_q, duty_d;
  logic [PS_W-1:0]        ps_q, ps_d;
  logic                   en_q, en_d;
  logic                   ien_q, ien_d;
  logic                   unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_comb begin
    duty_d = duty_q;
    ps_d   = ps_q;
    en_d   = en_q;
    ien_d  = ien_q;
    if (we_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (addr_i == AW'(4 * c)) duty_d[c] = wdata_i[CW-1:0];
      end
      if (addr_i == AW'(CTRL_OFS)) begin
        ps_d = {wdata_i[PS_HI_LSB +: NIB], wdata_i[PS_LO_LSB +: NIB]};
        en_d = wdata_i[EN_POS];
      end
      if (addr_i == AW'(IEN_OFS)) ien_d = wdata_i[IEN_POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      ps_q   <= '0;
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      ps_q   <= ps_d;
      en_q   <= en_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(4 * c)) rdata_o[CW-1:0] = duty_q[c];
    end
    if (addr_i == AW'(CTRL_OFS)) begin
      rdata_o[PS_LO_LSB +: NIB] = ps_q[NIB-1:0];
      rdata_o[PS_HI_LSB +: NIB] = ps_q[PS_W-1:NIB];
      rdata_o[EN_POS]           = en_q;
    end
    if (addr_i == AW'(IEN_OFS)) rdata_o[IEN_POS] = ien_q;
  end

  assign duty_stg_o = duty_q;
  assign ps_stg_o   = ps_q;
  assign en_o       = en_q;
  assign ien_o      = ien_q;

  // R2: a control write with the enable bit set is visible on the next clock
  a_r2_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(CTRL_OFS) && wdata_i[EN_POS]) |=> en_o);
  // R3: without a write to its address the interrupt flag keeps its value
  a_r3_ien_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == AW'(IEN_OFS)) |=> $stable(ien_o));
endmodule

// File: rtl/gpwm_timebase.sv
module gpwm_timebase
  import gpwm_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] ps_stg_i,
  output logic [CW-1:0]   cnt_o,
  output logic            wrap_o,
  output logic            load_o
);
  logic [PS_W-1:0] ps_act_q, ps_act_d;
  logic [PS_W-1:0] div_q, div_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            tick;

  assign tick   = en_i && (div_q == ps_act_q);
  assign wrap_o = tick && (cnt_q == '1);
  assign load_o = !en_i || wrap_o;

  always_comb begin
    div_d    = div_q;
    cnt_d    = cnt_q;
    ps_act_d = ps_act_q;
    if (!en_i) begin
      div_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      div_d = '0;
      cnt_d = cnt_q + CW'(1);
    end else begin
      div_d = div_q + PS_W'(1);
    end
    if (load_o) ps_act_d = ps_stg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      cnt_q    <= '0;
      ps_act_q <= '0;
    end else begin
      div_q    <= div_d;
      cnt_q    <= cnt_d;
      ps_act_q <= ps_act_d;
    end
  end

  assign cnt_o = cnt_q;

  // R4: the divider never runs past the working prescale value
  a_r4_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (div_q <= ps_act_q));
  // R4: the counter advances only on a local tick
  a_r4_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && div_q != ps_act_q) |=> $stable(cnt_q));
  // R10: while disabled the counter and divider are held at zero
  a_r10_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && div_q == '0));
  // R8: the working prescale changes only at a wrap or while disabled
  a_r8_ps_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_o) |=> $stable(ps_act_q));
endmodule

// File: rtl/gpwm_chan.sv
module gpwm_chan #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] duty_stg_i,
  output logic          pwm_o
);
  logic [CW-1:0] duty_act_q, duty_act_d;

  always_comb begin
    duty_act_d = duty_act_q;
    if (load_i) duty_act_d = duty_stg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) duty_act_q <= '0;
    else         duty_act_q <= duty_act_d;
  end

  assign pwm_o = en_i && (cnt_i <= duty_act_q);

  // R8: the working duty holds steady inside an enabled period
  a_r8_duty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> $stable(duty_act_q));
  // R5: every enabled output is high at count zero
  a_r5_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i == '0) |-> pwm_o);
  // R7: a full-scale duty never lets the output drop while enabled
  a_r7_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && duty_act_q == '1) |-> pwm_o);
endmodule

// File: rtl/gpwm_top.sv
module gpwm_top
  import gpwm_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           arst_ni,
  input  logic           bus_we_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  output logic [NCH-1:0] pwm_o,
  output logic           irq_o
);
  logic                   rst_s1_q, rst_s2_q;
  logic                   rst_n;
  logic [NCH-1:0][CW-1:0] duty_stg;
  logic [PS_W-1:0]        ps_stg;
  logic                   en, ien;
  logic [CW-1:0]          cnt;
  logic                   wrap, load;
  logic                   irq_q, irq_d;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q;

  gpwm_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .duty_stg_o (duty_stg),
    .ps_stg_o   (ps_stg),
    .en_o       (en),
    .ien_o      (ien)
  );

  gpwm_timebase #(.CW(CW)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (en),
    .ps_stg_i (ps_stg),
    .cnt_o    (cnt),
    .wrap_o   (wrap),
    .load_o   (load)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    gpwm_chan #(.CW(CW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .en_i       (en),
      .load_i     (load),
      .cnt_i      (cnt),
      .duty_stg_i (duty_stg[g]),
      .pwm_o      (pwm_o[g])
    );
  end

  assign irq_d = wrap && ien;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // R9: an interrupt pulse lasts one clock
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R9: an interrupt needs the interrupt flag in the clock before it
  a_r9_gated: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ien));
  // R10: a disabled block drives every output low
  a_r10_outputs_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |-> (pwm_o == '0));
endmodule

// File: tb/test_gpwm_top.sv
module test_gpwm_top;
  localparam int NCH = 4;

  logic            clk;
  logic            rst_n;
  logic            we;
  logic [7:0]      addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NCH-1:0]  pwm;
  logic            irq;

  int n_checks = 0;
  int n_errors = 0;
  bit cmp_on   = 1'b1;
  bit done     = 1'b0;

  int m_dstg[NCH];
  int m_dact[NCH];
  int m_ps_stg, m_ps_act, m_en, m_ien, m_div, m_cnt, m_irq, m_rel;

  gpwm_top #(.NCH(NCH)) i_gpwm_top (
    .clk_i       (clk),
    .arst_ni     (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pwm_o       (pwm),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_dstg[c] = 0; m_dact[c] = 0; end
      m_ps_stg = 0; m_ps_act = 0; m_en = 0; m_ien = 0;
      m_div = 0; m_cnt = 0; m_irq = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit tick, wrp, ld;
      tick = (m_en != 0) && (m_div == m_ps_act);
      wrp  = tick && (m_cnt == 255);
      ld   = (m_en == 0) || wrp;
      m_irq = (wrp && m_ien != 0) ? 1 : 0;
      if (m_en == 0) begin m_div = 0; m_cnt = 0; end
      else if (tick) begin m_div = 0; m_cnt = (m_cnt + 1) % 256; end
      else m_div++;
      if (ld) begin
        m_ps_act = m_ps_stg;
        for (int c = 0; c < NCH; c++) m_dact[c] = m_dstg[c];
      end
      if (we) begin
        for (int c = 0; c < NCH; c++)
          if (int'(addr) == 4 * c) m_dstg[c] = int'(wdata & 32'hFF);
        if (addr == 8'h50) begin
          m_ps_stg = int'(wdata & 32'hF) | (int'((wdata >> 11) & 32'hF) << 4);
          m_en = int'((wdata >> 9) & 32'h1);
        end
        if (addr == 8'h54) m_ien = int'(wdata & 32'h1);
      end
    end
  end

  function automatic int exp_rd(int a);
    if (a == 'h50) return (m_ps_stg & 15) | (m_en << 9) | ((m_ps_stg >> 4) << 11);
    if (a == 'h54) return m_ien;
    if (a % 4 == 0 && a / 4 < NCH) return m_dstg[a / 4];
    return 0;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [NCH-1:0] ep;
      for (int c = 0; c < NCH; c++) ep[c] = (m_en != 0) && (m_cnt <= m_dact[c]);
      check("R5 pwm vs model", pwm === ep, int'(pwm), int'(ep));
      check("R9 irq vs model", irq === m_irq[0], int'(irq), m_irq);
      check("R1 rdata vs model", rdata === exp_rd(int'(addr)), int'(rdata), exp_rd(int'(addr)));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = 8'(a); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (irq !== 1'b1) @(negedge clk);
  endtask

  task automatic measure(int ch, int ps, int exp_hi, string tag);
    int hi = 0;
    wait_irq();
    for (int k = 0; k < 256 * (ps + 1); k++) begin
      if (pwm[ch] === 1'b1) hi++;
      @(negedge clk);
    end
    check(tag, hi == exp_hi, hi, exp_hi);
  endtask

  initial begin
    #(4 * 200000);
    n_errors++;
    $display("FAIL watchdog expired at %0t: actual 0 expected 1", $time);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int cnt_irq, cnt_hi;
    rst_n = 1'b0; we = 1'b0; addr = 8'h50; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    check("R11 reset pwm", pwm === '0, int'(pwm), 0);
    check("R11 reset ctrl", rdata === 32'h0, int'(rdata), 0);
    check("R11 reset irq", irq === 1'b0, int'(irq), 0);

    wr('h00, 32'h0);
    wr('h04, 32'd100);
    wr('h08, 32'd255);
    wr('h0C, 32'h1234_5607);
    addr = 8'h0C; @(negedge clk);
    check("R1 duty upper bits dropped", rdata === 32'h7, int'(rdata), 7);
    wr('h54, 32'hFFFF_FFFF);
    addr = 8'h54; @(negedge clk);
    check("R3 ien readback", rdata === 32'h1, int'(rdata), 1);
    wr('h50, 32'h0000_0200);

    measure(0, 0, 1, "R6 duty 0 one tick");
    measure(2, 0, 256, "R7 duty 255 full period");
    measure(1, 0, 101, "R5 duty 100 width");
    measure(3, 0, 8, "R5 duty 7 width");

    // R8: mid-period duty write holds until the wrap
    wait_irq();
    wr('h04, 32'd10);
    repeat (46) @(negedge clk);
    check("R8 old duty kept mid period", pwm[1] === 1'b1, int'(pwm[1]), 1);
    measure(1, 0, 11, "R8 new duty after wrap");

    // R4: prescale 19 split across both nibble fields
    wr('h50, 32'h0000_0A03);
    addr = 8'h50; @(negedge clk);
    check("R2 ctrl readback", rdata === 32'h0A03, int'(rdata), 'hA03);
    measure(1, 19, 220, "R4 prescale 19 width");
    measure(0, 19, 20, "R4 prescale 19 single tick");

    // R10: disable holds outputs and interrupt low
    wr('h50, 32'h0);
    cnt_irq = 0; cnt_hi = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (irq === 1'b1) cnt_irq++;
      if (pwm !== '0) cnt_hi++;
    end
    check("R10 outputs low when disabled", cnt_hi == 0, cnt_hi, 0);
    check("R9 no irq when disabled", cnt_irq == 0, cnt_irq, 0);

    // R10: re-enable starts at count 0 with all outputs high
    @(posedge clk); #1;
    we = 1'b1; addr = 8'h50; wdata = 32'h200;
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk);
    check("R10 fresh period all high", pwm === 4'hF, int'(pwm), 'hF);

    // R9: interrupt flag cleared suppresses the pulse
    wr('h54, 32'h0);
    cnt_irq = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (irq === 1'b1) cnt_irq++;
    end
    check("R9 no irq when flag clear", cnt_irq == 0, cnt_irq, 0);

    // R2: reserved bits and unmapped address
    wr('h50, 32'hFFFF_FFFF);
    addr = 8'h50; @(negedge clk);
    check("R2 reserved bits read zero", rdata === 32'h7A0F, int'(rdata), 'h7A0F);
    wr('h50, 32'h0);
    wr('h60, 32'hFFFF_FFFF);
    addr = 8'h60; @(negedge clk);
    check("R2 unmapped reads zero", rdata === 32'h0, int'(rdata), 0);

    // R11: reset in the middle of operation
    wr('h50, 32'h200);
    addr = 8'h50;
    repeat (20) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check("R11 mid reset pwm low", pwm === '0, int'(pwm), 0);
    check("R11 mid reset ctrl clear", rdata === 32'h0, int'(rdata), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule